// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference clock and produces a signed frequency-offset word for an external fractional divider or digitally controlled oscillator. Fed with that word, the synthesized clock sweeps back and forth across a programmed band. This lowers the peak spectral energy at the fundamental and at its harmonics.

Four control inputs set the sweep. The spread select sets the width of the band. The range select sets the length of one modulation period in reference cycles. The mode input chooses between a band centred on the nominal frequency and a band hanging below it. A disable input parks the offset at the top of the band. The sweep has a nonlinear shape. The offset moves slowly through the middle of the band and fast near its edges. It moves in small steps that add up. The offset is expressed in units of 2^-16 of the nominal frequency.

Top module: `ssc_profile_gen`

## Requirements
- R1: The half spread H is HALF_LSB0 shifted left by spread_sel (00, 01, 10, 11 give 1x, 2x, 4x and 8x). With the default of 410 this gives total spreads of about 1.25, 2.5, 5 and 10 % of nominal.
- R2: With center_mode=1 and modulation running, the offset stays within [-H, +H].
- R3: With center_mode=0 and modulation running, the offset stays within [-2H, 0], so the output never exceeds nominal.
- R4: mod_off is active high. While the latched mod_off is 1, the offset holds at the upper band edge: +H in center mode and 0 in down mode.
- R5: One modulation period lasts PERIOD_LOW cycles for range_sel=00, PERIOD_MID for 01, and PERIOD_HIGH for 10 or 11.
- R6: Each period starts at the upper band edge, reaches the lower edge at segment 32 and climbs back.
- R7: A period of P cycles is cut into 64 segments. Local cycle t belongs to segment s=floor(64t/P). For m = s mod 32, let k=16-m when m<16 and k=m-16 otherwise. The magnitude is floor(k*k*H/256). The sign is positive for s<16 or s>=48 and negative otherwise. In down mode, H is then subtracted.
- R8: The step between adjacent segments is larger next to the band edges than next to the band centre.
- R9: spread_sel, range_sel, center_mode and mod_off are latched only at the first cycle of a period. Changes made inside a period have no effect until the next period starts.
- R10: rst is synchronous and active high. While rst is high and in the first cycle after it, the offset equals the upper band edge of the inputs present during reset, and the period restarts at t=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_sel | input | 2 | Band width select |
| range_sel | input | 2 | Period length select |
| center_mode | input | 1 | 1 = band centred on nominal, 0 = band below nominal |
| mod_off | input | 1 | 1 = sweep parked at the upper edge, 0 = sweep running |
| offset | output | 16 | Signed frequency offset, LSB = 2^-16 of nominal |

## Verification
The bench builds the block with periods of 75, 150 and 300 cycles instead of the defaults, and keeps the default half spread of 410.

The 75-cycle period is not a multiple of 64. This brings uneven segment lengths within reach, along with the extra-long segments they produce. The short periods let hundreds of period boundaries pass within the run. Each boundary re-latches randomly changing controls, so mid-period changes and mode switches at boundaries are exercised many times.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int QSEGS = 16;        // segments per quarter sweep
  localparam int NSEG  = 4 * QSEGS; // segments per period
  localparam int FRAC  = 12;        // shape full scale = 2^FRAC

  typedef struct packed {
    logic [1:0] spread;
    logic [1:0] range;
    logic       center;
    logic       mod_off;
  } ssc_cfg_t;
endpackage

// File: rtl/ssc_shape_lut.sv
module ssc_shape_lut #(
  parameter int QSEGS = 16,
  parameter int FRAC  = 12,
  parameter int K_W   = $clog2(QSEGS + 1)
) (
  input  logic [K_W-1:0] k,
  output logic [FRAC:0]  level
);
  // Cumulative sum of odd-weighted slopes: level(k) = k^2 / QSEGS^2 of full scale
  logic [FRAC:0] tbl [0:QSEGS];

  for (genvar i = 0; i <= QSEGS; i++) begin : g_lvl
    assign tbl[i] = (FRAC+1)'((i * i * (1 << FRAC)) / (QSEGS * QSEGS));
  end

  always_comb begin
    if (int'(k) <= QSEGS) level = tbl[k];
    else                  level = tbl[QSEGS];
  end

  always_comb begin
    assert (level <= (FRAC+1)'(1 << FRAC))
      else $error("assert_shape_bound_R7 failed");
  end
endmodule

// File: rtl/ssc_period_timer.sv
module ssc_period_timer #(
  parameter int CNT_W = 12,
  parameter int NSEG  = 64,
  parameter int SEG_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SEG_W-1:0] seg_q,
  output logic [SEG_W-1:0] seg_nxt,
  output logic             last
);
  logic [CNT_W:0]   acc_q, acc_sum, acc_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    last    = (cnt_q == period - 1'b1);
    acc_sum = acc_q + (CNT_W+1)'(NSEG);
    if (rst || last) begin
      cnt_nxt = '0;
      acc_nxt = '0;
      seg_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
      if (acc_sum >= {1'b0, period}) begin
        acc_nxt = acc_sum - {1'b0, period};
        seg_nxt = seg_q + 1'b1;
      end else begin
        acc_nxt = acc_sum;
        seg_nxt = seg_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
    acc_q <= acc_nxt;
    seg_q <= seg_nxt;
  end

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt_q == '0) && (seg_q == '0));
  assert_seg_step_R7: assert property (@(posedge clk) disable iff (rst)
    !last |=> (seg_q == $past(seg_q)) || (seg_q == SEG_W'($past(seg_q) + 1'b1)));
  assert_last_seg_R7: assert property (@(posedge clk) disable iff (rst)
    last |-> (seg_q == SEG_W'(NSEG - 1)));
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int PERIOD_LOW  = 750,
  parameter int PERIOD_MID  = 1500,
  parameter int PERIOD_HIGH = 3000,
  parameter int HALF_LSB0   = 410,
  parameter int OFS_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              spread_sel,
  input  logic [1:0]              range_sel,
  input  logic                    center_mode,
  input  logic                    mod_off,
  output logic signed [OFS_W-1:0] offset
);
  import ssc_pkg::*;

  localparam int CNT_W = $clog2(PERIOD_HIGH + 1);
  localparam int SEG_W = $clog2(NSEG);
  localparam int K_W   = $clog2(QSEGS + 1);
  localparam int PRD_W = FRAC + OFS_W + 2;

  ssc_cfg_t cfg_q, cfg_in, cfg_nxt;
  logic [CNT_W-1:0] period, cnt_q;
  logic [SEG_W-1:0] seg_q, seg_nxt;
  logic             last;

  logic [SEG_W-2:0]         m;
  logic [K_W-1:0]           k;
  logic [FRAC:0]            level;
  logic                     pos;
  logic signed [OFS_W:0]    h_nxt, h_cur, mag, val;
  logic [PRD_W-1:0]         prod;
  logic signed [OFS_W-1:0]  offset_q;

  assign cfg_in  = '{spread: spread_sel, range: range_sel,
                     center: center_mode, mod_off: mod_off};
  // Settings enter only at a period boundary or in reset
  assign cfg_nxt = (rst || last) ? cfg_in : cfg_q;

  always_comb begin
    case (cfg_q.range)
      2'b00:   period = CNT_W'(PERIOD_LOW);
      2'b01:   period = CNT_W'(PERIOD_MID);
      default: period = CNT_W'(PERIOD_HIGH);
    endcase
  end

  ssc_period_timer #(.CNT_W(CNT_W), .NSEG(NSEG), .SEG_W(SEG_W)) u_timer (
    .clk(clk), .rst(rst), .period(period),
    .cnt_q(cnt_q), .seg_q(seg_q), .seg_nxt(seg_nxt), .last(last)
  );

  // Fold segment index into distance k from band centre and a sign
  always_comb begin
    m   = seg_nxt[SEG_W-2:0];
    if (int'(m) < QSEGS) k = K_W'(QSEGS - int'(m));
    else                 k = K_W'(int'(m) - QSEGS);
    pos = (seg_nxt[SEG_W-1] == seg_nxt[SEG_W-2]);
  end

  ssc_shape_lut #(.QSEGS(QSEGS), .FRAC(FRAC), .K_W(K_W)) u_shape (
    .k(k), .level(level)
  );

  assign h_nxt = (OFS_W+1)'(HALF_LSB0) <<< cfg_nxt.spread;
  assign h_cur = (OFS_W+1)'(HALF_LSB0) <<< cfg_q.spread;

  always_comb begin
    prod = PRD_W'(level) * PRD_W'($unsigned(h_nxt));
    mag  = (OFS_W+1)'(prod >> FRAC);
    val  = pos ? mag : -mag;
    if (!cfg_nxt.center) val = val - h_nxt;
    if (cfg_nxt.mod_off) val = cfg_nxt.center ? h_nxt : '0;
  end

  always_ff @(posedge clk) begin
    cfg_q    <= cfg_nxt;
    offset_q <= val[OFS_W-1:0];
  end

  assign offset = offset_q;

  assert_band_center_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.center && !cfg_q.mod_off) |-> (offset_q >= -h_cur) && (offset_q <= h_cur));
  assert_band_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.center && !cfg_q.mod_off) |-> (offset_q >= -(h_cur <<< 1)) && (offset_q <= 0));
  assert_park_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_q.mod_off |-> (offset_q == (cfg_q.center ? h_cur : '0)));
  assert_start_top_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> (offset_q == (cfg_q.center ? h_cur : '0)));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(cfg_q));
endmodule

// File: tb/ssc_profile_gen_test.sv
module ssc_profile_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 75, PM = 150, PH = 300, HALF0 = 410;

  logic clk = 0, rst = 1;
  logic [1:0] spread_sel = 2'd3, range_sel = 2'd0;
  logic center_mode = 1, mod_off = 0;
  logic signed [15:0] offset;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_t = 0, m_sp = 3, m_rg = 0;
  bit m_ctr = 1, m_off = 0;
  bit cap_en = 0;
  int obs [0:63];

  ssc_profile_gen #(.PERIOD_LOW(PL), .PERIOD_MID(PM), .PERIOD_HIGH(PH),
                    .HALF_LSB0(HALF0), .OFS_W(16)) uut (
    .clk(clk), .rst(rst), .spread_sel(spread_sel), .range_sel(range_sel),
    .center_mode(center_mode), .mod_off(mod_off), .offset(offset));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(int rg);
    return (rg == 0) ? PL : (rg == 1) ? PM : PH;
  endfunction

  function automatic int half_of(int sp);
    return HALF0 << sp;
  endfunction

  function automatic int exp_off(int t, int p, int sp, bit ctr, bit off);
    int h, s, m, k, mag, v;
    h = half_of(sp);
    if (off) return ctr ? h : 0;
    s = (t * 64) / p;
    m = s % 32;
    k = (m < 16) ? 16 - m : m - 16;
    mag = (k * k * h) >> 8;
    v = (s < 16 || s >= 48) ? mag : -mag;
    return ctr ? v : v - h;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", tag, act, expv, m_t);
    end
  endtask

  task automatic check_now();
    int p, e, h, s, sp;
    string tag;
    p = period_of(m_rg);
    h = half_of(m_sp);
    e = exp_off(m_t, p, m_sp, m_ctr, m_off);
    s = (m_t * 64) / p;
    sp = (m_t == 0) ? -1 : ((m_t - 1) * 64) / p;
    if (m_off) tag = "R4 parked at upper edge";
    else if (m_t == 0) tag = "R5 period boundary at P cycles";
    else if (spread_sel != 2'(m_sp) || range_sel != 2'(m_rg) ||
             center_mode != m_ctr || mod_off != m_off) tag = "R9 mid-period change ignored";
    else tag = "R7 profile value";
    check(int'(offset) == e, tag, int'(offset), e);
    if (!m_off) begin
      if (m_ctr) check(int'(offset) >= -h && int'(offset) <= h, "R2 center band", int'(offset), h);
      else       check(int'(offset) >= -2*h && int'(offset) <= 0, "R3 down band", int'(offset), -2*h);
      if (m_t == 0) check(int'(offset) == (m_ctr ? h : 0), "R6 start at upper edge", int'(offset), m_ctr ? h : 0);
      if (s == 32 && sp == 31)
        check(int'(offset) == (m_ctr ? -h : -2*h), "R1 R6 lower edge from spread", int'(offset), m_ctr ? -h : -2*h);
    end
    if (cap_en && s != sp) obs[s] = int'(offset);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst || m_t == period_of(m_rg) - 1) begin
      m_t = 0; m_sp = spread_sel; m_rg = range_sel; m_ctr = center_mode; m_off = mod_off;
    end else m_t++;
    @(negedge clk);
    check_now();
  endtask

  task automatic do_reset(int sp, int rg, bit ctr, bit off);
    spread_sel = 2'(sp); range_sel = 2'(rg); center_mode = ctr; mod_off = off;
    rst = 1;
    tick(); tick();
    rst = 0;
    // R10: after release, period at t=0 and offset at the reset-time upper edge
    check(int'(offset) == (ctr ? half_of(sp) : 0), "R10 reset state", int'(offset), ctr ? half_of(sp) : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7319);
    @(negedge clk);
    do_reset(3, 0, 1, 0);
    // Directed: 10 % center, capture one period for shape checks
    cap_en = 1;
    for (int i = 0; i < PL; i++) tick();
    cap_en = 0;
    check((obs[0] - obs[1]) > (obs[16] - obs[17]), "R8 step at top edge vs centre", obs[0] - obs[1], obs[16] - obs[17]);
    check((obs[63] - obs[62]) > (obs[48] - obs[47]), "R8 step at rising edge vs centre", obs[63] - obs[62], obs[48] - obs[47]);
    check(obs[32] == -half_of(3), "R6 bottom at segment 32", obs[32], -half_of(3));
    // Directed: down spread 2.5 %, mid range
    spread_sel = 2'd1; range_sel = 2'd1; center_mode = 0;
    for (int i = 0; i < 2 * PM; i++) tick();
    // Directed: parked, both modes, range code 11 maps to high
    mod_off = 1; range_sel = 2'd3;
    for (int i = 0; i < PH; i++) tick();
    center_mode = 1;
    for (int i = 0; i < PH + 5; i++) tick();
    mod_off = 0; spread_sel = 2'd0;
    // Random phase: controls change at arbitrary cycles
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 60 == 0) begin
        spread_sel = 2'($urandom); range_sel = 2'($urandom);
        center_mode = 1'($urandom); mod_off = ($urandom % 4 == 0);
      end
      tick();
    end
    // Reset in the middle of a period with new controls
    for (int i = 0; i < 37; i++) tick();
    do_reset(2, 2, 0, 0);
    for (int i = 0; i < PH; i++) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule